// File: doc/BRIEF.md
# Serial-Bus Byte Memory Slave

This block is the slave side of a four-wire serial bus in clock mode 0. It fronts a 512-byte array of byte-wide storage. The bus pins (serial clock, active-low select, serial in) are brought into the system clock domain through a synchroniser. The block detects serial clock edges with the system clock, so the serial clock must run several times slower than `clk_i`. Each transaction opens with an 8-bit opcode. The opcode picks one of six commands: arm writes, disarm writes, read status, write status, read array and write array. For array commands, the ninth address bit is carried in bit 3 of the opcode.

Array and status writes are staged while select is low. They take effect only when select rises on a byte boundary. A commit disarms writes and starts a busy interval of `BUSY_CYCLES` system clocks that models the cell write time. During that interval only the status read is served. A status field of two bits selects a protected upper region of the array. The same status byte also holds two watchdog-select bits, which the block stores and reports.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset, `so_en_o` is low, the status byte reads 0x00, and every array byte reads 0x00.
- R2: Opcode 0x06 sets the write-enable bit (status bit 1). Opcode 0x04 clears it. Both are one-byte commands.
- R3: Opcode 0x05 returns the status byte MSB first, repeated for as long as the clock runs. Bit 0 is busy, bit 1 is write-enable, bits 3:2 are protect, bits 5:4 are watchdog-select, and bits 7:6 read 0.
- R4: Opcode 0x01 followed by one byte copies bits 5:2 of that byte into the status when select rises, provided write-enable was set. Without write-enable, the status is unchanged.
- R5: Opcode 0000_A011 followed by a low address byte reads the array from address {A,low}. Data is sent MSB first and SO changes after falling clock edges. The address increments per byte and wraps from 0x1FF to 0x000.
- R6: Opcode 0000_A010, a low address byte and 1 to 16 data bytes store those bytes from {A,low} when select rises. The low four address bits wrap inside the aligned 16-byte page.
- R7: An array write issued while write-enable is clear changes no byte.
- R8: If select rises in the middle of a byte, the pending write is dropped and write-enable is left as it was.
- R9: A commit clears write-enable and sets busy for `BUSY_CYCLES` clocks. While busy, every opcode except 0x05 is ignored.
- R10: Protect value 01 blocks writes to 0x180-0x1FF, 10 blocks 0x100-0x1FF and 11 blocks the whole array. Blocked bytes keep their old value; unblocked bytes of the same burst are stored.
- R11: `so_en_o` is low whenever select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from master |
| csn_i | input | 1 | Active-low select |
| si_i | input | 1 | Serial data into the block |
| so_o | output | 1 | Serial data out of the block |
| so_en_o | output | 1 | Drive enable for the serial output pad |

## Verification
The bench builds the block with `BUSY_CYCLES` at 1500, `PAGE_BYTES` at 16 and two synchroniser stages. The shortened busy interval is still longer than a full two-byte status read and a three-byte read attempt. This lets a single busy window show busy set, write-enable cleared, a rejected arm command and an unserved read, after which polling ends quickly. Sixteen-byte pages make the page wrap and the protected-region boundaries at 0x180 and 0x100 reachable with short bursts.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;
  localparam int ADDR_W = 9;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  // opcode bits {7:4,2:0}; bit 3 carries the high address bit
  localparam logic [6:0] KEY_READ  = 7'b0000_011;
  localparam logic [6:0] KEY_WRITE = 7'b0000_010;

  typedef enum logic [2:0] {
    ST_OPC, ST_ADDR, ST_RDATA, ST_WDATA, ST_SRWR, ST_SRRD, ST_SKIP
  } spi_st_e;

  function automatic logic addr_locked(input logic [1:0] bp, input logic [ADDR_W-1:0] a);
    case (bp)
      2'd0:    return 1'b0;
      2'd1:    return a[8:7] == 2'b11;
      2'd2:    return a[8];
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic csn_i,
  input  logic si_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic cs_act_o,
  output logic cs_end_o,
  output logic si_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sck_p, csn_p, si_p;
  logic         sck_d, csn_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_p <= '0;
      csn_p <= '1;
      si_p  <= '0;
      sck_d <= 1'b0;
      csn_d <= 1'b1;
    end else begin
      sck_p <= {sck_p[MSB-1:0], sck_i};
      csn_p <= {csn_p[MSB-1:0], csn_i};
      si_p  <= {si_p[MSB-1:0], si_i};
      sck_d <= sck_p[MSB];
      csn_d <= csn_p[MSB];
    end
  end

  assign sck_rise_o = sck_p[MSB] & ~sck_d;
  assign sck_fall_o = ~sck_p[MSB] & sck_d;
  assign cs_act_o   = ~csn_p[MSB];
  assign cs_end_o   = csn_p[MSB] & ~csn_d;
  assign si_o       = si_p[MSB];
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_act_i,
  input  logic       sck_rise_i,
  input  logic       sck_fall_i,
  input  logic       si_i,
  input  logic       load_i,
  input  logic [7:0] load_byte_i,
  output logic [2:0] bit_cnt_o,
  output logic       byte_done_o,
  output logic [7:0] rx_byte_o,
  output logic       so_o
);
  logic [6:0] rx_q;
  logic [2:0] cnt_q;
  logic [7:0] tx_q;
  logic       so_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q  <= '0;
      cnt_q <= '0;
    end else if (!cs_act_i) begin
      cnt_q <= '0;
    end else if (sck_rise_i) begin
      rx_q  <= {rx_q[5:0], si_i};
      cnt_q <= cnt_q + 3'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      so_q <= 1'b0;
    end else if (!cs_act_i) begin
      tx_q <= '0;
      so_q <= 1'b0;
    end else if (load_i) begin
      tx_q <= load_byte_i;
    end else if (sck_fall_i) begin
      so_q <= tx_q[7];
      tx_q <= {tx_q[6:0], 1'b0};
    end
  end

  assign bit_cnt_o   = cnt_q;
  assign byte_done_o = cs_act_i & sck_rise_i & (cnt_q == 3'd7);
  assign rx_byte_o   = {rx_q, si_i};
  assign so_o        = so_q;
endmodule

// File: rtl/spi_eeprom_array.sv
module spi_eeprom_array import spi_eeprom_pkg::*; #(
  parameter int PAGE_BYTES = 16
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                we_i,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_i,
  input  logic [PAGE_BYTES-1:0][7:0]          data_i,
  input  logic [PAGE_BYTES-1:0]               mask_i,
  input  logic [1:0]                          bp_i,
  input  logic [ADDR_W-1:0]                   rd_addr_i,
  output logic [7:0]                          rd_data_o
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int DEPTH  = 1 << ADDR_W;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < DEPTH; j++) mem_q[j] <= '0;
    end else if (we_i) begin
      for (int k = 0; k < PAGE_BYTES; k++) begin
        if (mask_i[k] && !addr_locked(bp_i, {page_i, PAGE_W'(k)}))
          mem_q[{page_i, PAGE_W'(k)}] <= data_i[k];
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave import spi_eeprom_pkg::*; #(
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 1250000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic csn_i,
  input  logic si_i,
  output logic so_o,
  output logic so_en_o
);
  localparam int PAGE_W   = $clog2(PAGE_BYTES);
  localparam int PAGE_N_W = ADDR_W - PAGE_W;
  localparam int BUSY_W   = $clog2(BUSY_CYCLES + 1);

  logic sck_rise, sck_fall, cs_act, cs_end, si_s;
  logic [2:0] bit_cnt;
  logic       byte_done;
  logic [7:0] rx_byte;
  logic       tx_load;
  logic [7:0] tx_byte;

  spi_st_e                   state_q;
  logic                      rd_q, a8_q, drv_q;
  logic [ADDR_W-1:0]         addr_q, rd_addr;
  logic [7:0]                rd_data;
  logic [PAGE_N_W-1:0]       page_q;
  logic [PAGE_W-1:0]         wptr_q;
  logic [PAGE_BYTES-1:0][7:0] pbuf_q;
  logic [PAGE_BYTES-1:0]     mask_q;
  logic [3:0]                sr_new_q;
  logic                      sr_new_v_q;
  logic                      wel_q;
  logic [1:0]                bp_q, wd_q;
  logic [BUSY_W-1:0]         busy_cnt_q;
  logic                      busy, opc_done, commit, arr_we;
  logic [6:0]                op_key;
  logic [7:0]                status;

  spi_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sck_i, .csn_i, .si_i,
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall),
    .cs_act_o(cs_act), .cs_end_o(cs_end), .si_o(si_s)
  );

  spi_byte_shifter u_shift (
    .clk_i, .rst_ni,
    .cs_act_i(cs_act), .sck_rise_i(sck_rise), .sck_fall_i(sck_fall), .si_i(si_s),
    .load_i(tx_load), .load_byte_i(tx_byte),
    .bit_cnt_o(bit_cnt), .byte_done_o(byte_done), .rx_byte_o(rx_byte), .so_o(so_o)
  );

  spi_eeprom_array #(.PAGE_BYTES(PAGE_BYTES)) u_array (
    .clk_i, .rst_ni,
    .we_i(arr_we), .page_i(page_q), .data_i(pbuf_q), .mask_i(mask_q), .bp_i(bp_q),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  assign busy     = busy_cnt_q != '0;
  assign status   = {2'b00, wd_q, bp_q, wel_q, busy};
  assign opc_done = byte_done && state_q == ST_OPC;
  assign op_key   = {rx_byte[7:4], rx_byte[2:0]};
  assign rd_addr  = (state_q == ST_ADDR) ? {a8_q, rx_byte} : addr_q;
  // commit only on a clean byte boundary at select release
  assign arr_we   = cs_end && bit_cnt == 3'd0 && state_q == ST_WDATA && |mask_q;
  assign commit   = arr_we || (cs_end && bit_cnt == 3'd0 && sr_new_v_q);
  assign so_en_o  = drv_q & cs_act;

  always_comb begin
    tx_load = 1'b0;
    tx_byte = rd_data;
    if (byte_done) begin
      unique case (state_q)
        ST_OPC:   if (rx_byte == OP_RDSR) begin tx_load = 1'b1; tx_byte = status; end
        ST_SRRD:  begin tx_load = 1'b1; tx_byte = status; end
        ST_ADDR:  tx_load = rd_q;
        ST_RDATA: tx_load = 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_OPC;
      rd_q       <= 1'b0;
      a8_q       <= 1'b0;
      drv_q      <= 1'b0;
      addr_q     <= '0;
      page_q     <= '0;
      wptr_q     <= '0;
      pbuf_q     <= '0;
      mask_q     <= '0;
      sr_new_q   <= '0;
      sr_new_v_q <= 1'b0;
      wel_q      <= 1'b0;
      bp_q       <= '0;
      wd_q       <= '0;
    end else begin
      if (commit) begin
        wel_q <= 1'b0;
        if (sr_new_v_q) {wd_q, bp_q} <= sr_new_q;
      end
      if (!cs_act) begin
        state_q    <= ST_OPC;
        mask_q     <= '0;
        sr_new_v_q <= 1'b0;
        drv_q      <= 1'b0;
      end else begin
        if (sck_fall && (state_q == ST_RDATA || state_q == ST_SRRD)) drv_q <= 1'b1;
        if (byte_done) begin
          unique case (state_q)
            ST_OPC: begin
              if (rx_byte == OP_RDSR) state_q <= ST_SRRD;
              else if (busy) state_q <= ST_SKIP;
              else if (rx_byte == OP_WREN) begin wel_q <= 1'b1; state_q <= ST_SKIP; end
              else if (rx_byte == OP_WRDI) begin wel_q <= 1'b0; state_q <= ST_SKIP; end
              else if (rx_byte == OP_WRSR) state_q <= wel_q ? ST_SRWR : ST_SKIP;
              else if (op_key == KEY_READ) begin
                a8_q <= rx_byte[3]; rd_q <= 1'b1; state_q <= ST_ADDR;
              end else if (op_key == KEY_WRITE && wel_q) begin
                a8_q <= rx_byte[3]; rd_q <= 1'b0; state_q <= ST_ADDR;
              end else state_q <= ST_SKIP;
            end
            ST_ADDR: begin
              if (rd_q) begin
                addr_q  <= rd_addr + 1'b1;
                state_q <= ST_RDATA;
              end else begin
                page_q  <= rd_addr[ADDR_W-1:PAGE_W];
                wptr_q  <= rd_addr[PAGE_W-1:0];
                state_q <= ST_WDATA;
              end
            end
            ST_RDATA: addr_q <= addr_q + 1'b1;
            ST_WDATA: begin
              pbuf_q[wptr_q] <= rx_byte;
              mask_q[wptr_q] <= 1'b1;
              wptr_q         <= wptr_q + 1'b1;
            end
            ST_SRWR: begin
              sr_new_q   <= rx_byte[5:2];
              sr_new_v_q <= 1'b1;
              state_q    <= ST_SKIP;
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_cnt_q <= '0;
    else if (commit)  busy_cnt_q <= BUSY_W'(BUSY_CYCLES);
    else if (busy)    busy_cnt_q <= busy_cnt_q - 1'b1;
  end
endmodule

// File: rtl/spi_eeprom_slave_chk.sv
module spi_eeprom_slave_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       csn_i,
  input logic       so_en_o,
  input logic       commit,
  input logic       wel,
  input logic       busy,
  input logic       opc_done,
  input logic [7:0] opcode,
  input logic [3:0] sr_bits
);
  AST_SO_QUIET_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_i && $past(csn_i) && $past(csn_i, 2) |-> !so_en_o); // R11

  AST_COMMIT_NEEDS_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> wel); // R7

  AST_COMMIT_BUSY_DISARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> busy && !wel); // R9

  AST_ARM_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opc_done && opcode == 8'h06 && !busy |=> wel); // R2

  AST_ARM_BLOCKED_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opc_done && busy && !wel |=> !wel); // R9

  AST_STATUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable(sr_bits)); // R4
endmodule

bind spi_eeprom_slave spi_eeprom_slave_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .csn_i    (csn_i),
  .so_en_o  (so_en_o),
  .commit   (commit),
  .wel      (wel_q),
  .busy     (busy),
  .opc_done (opc_done),
  .opcode   (rx_byte),
  .sr_bits  ({wd_q, bp_q})
);

// File: tb/spi_eeprom_slave_bench.sv
module spi_eeprom_slave_bench;
  localparam int BUSY = 1500;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, csn = 1'b1, si = 1'b0;
  logic so, so_en;

  always #2 clk = ~clk;

  spi_eeprom_slave #(.PAGE_BYTES(16), .BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) u_spi_eeprom_slave (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .csn_i(csn), .si_i(si),
    .so_o(so), .so_en_o(so_en)
  );

  int n_chk = 0, n_fail = 0;
  int idle_viol = 0, csn_hi_run = 0, busy_left = 0;
  bit en_seen;
  logic [7:0] mem_m [512];
  bit wel_m;
  logic [1:0] bp_m, wd_m;

  // per-clock reference: deselected output enable and busy countdown
  always @(negedge clk) begin
    if (csn) csn_hi_run++; else csn_hi_run = 0;
    if (rst_n && csn_hi_run >= 4 && so_en) idle_viol++;
    if (busy_left > 0) busy_left--;
  end

  function automatic logic [7:0] st_m();
    return {2'b00, wd_m, bp_m, wel_m, busy_left > 0};
  endfunction

  function automatic bit locked_m(logic [1:0] bp, int a);
    if (bp == 2'd1) return a >= 'h180;
    if (bp == 2'd2) return a >= 'h100;
    return bp == 2'd3;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] d, output logic [7:0] q);
    for (int i = 7; i >= 0; i--) begin
      si = d[i];
      tick(HALF);
      q[i] = so;
      en_seen |= so_en;
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic open_cmd();
    csn = 1'b0; en_seen = 1'b0; tick(HALF);
  endtask

  task automatic close_cmd();
    tick(HALF); csn = 1'b1; tick(12);
  endtask

  task automatic one_byte(input logic [7:0] op);
    logic [7:0] q;
    bit idle;
    idle = busy_left == 0;
    open_cmd(); xfer(op, q); close_cmd();
    if (idle && op == 8'h06) wel_m = 1'b1;
    if (idle && op == 8'h04) wel_m = 1'b0;
  endtask

  task automatic rdsr(output logic [7:0] st, output logic [7:0] exp);
    logic [7:0] q;
    open_cmd(); xfer(8'h05, q); exp = st_m(); xfer(8'h00, st); close_cmd();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] q;
    bit ok;
    ok = wel_m && busy_left == 0;
    open_cmd(); xfer(8'h01, q); xfer(v, q); close_cmd();
    if (ok) begin {wd_m, bp_m} = v[5:2]; wel_m = 1'b0; busy_left = BUSY; end
  endtask

  task automatic wr(input int a, input logic [7:0] d[$], input int partial);
    logic [7:0] q;
    bit ok;
    int idx;
    ok = wel_m && busy_left == 0;
    open_cmd();
    xfer({4'b0, a[8], 3'b010}, q);
    xfer(a[7:0], q);
    foreach (d[k]) xfer(d[k], q);
    for (int i = 0; i < partial; i++) begin
      si = 1'b1; tick(HALF); sck = 1'b1; tick(HALF); sck = 1'b0;
    end
    close_cmd();
    if (ok && partial == 0 && d.size() > 0) begin
      foreach (d[k]) begin
        idx = (a & 'h1F0) | ((a + k) & 'hF);
        if (!locked_m(bp_m, idx)) mem_m[idx] = d[k];
      end
      wel_m = 1'b0;
      busy_left = BUSY;
    end
  endtask

  task automatic rd(input string tag, input int a, input int n);
    logic [7:0] q;
    bit busy_now;
    busy_now = busy_left > 0;
    open_cmd();
    xfer({4'b0, a[8], 3'b011}, q);
    xfer(a[7:0], q);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, q);
      if (!busy_now) chk(tag, q, mem_m[(a + k) % 512]);
    end
    close_cmd();
    if (busy_now) chk({tag, " read ignored while busy"}, en_seen, 0);
  endtask

  task automatic wait_idle();
    logic [7:0] st, e;
    int polls = 0;
    do begin rdsr(st, e); polls++; end while (st[0] && polls < 40);
    chk("R9 busy released", st[0], 0);
    chk("R9 busy length vs model", busy_left <= 30, 1);
    busy_left = 0;
  endtask

  initial begin
    tick(150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] st, e, s2, q;
    for (int i = 0; i < 512; i++) mem_m[i] = 8'h00;
    wel_m = 1'b0; bp_m = 2'd0; wd_m = 2'd0;
    tick(5); rst_n = 1'b1; tick(5);

    chk("R1 so_en after reset", so_en, 0);
    rdsr(st, e); chk("R1 R3 status after reset", st, 8'h00);
    rd("R1 array after reset", 'h000, 2);

    one_byte(8'h06); rdsr(st, e); chk("R2 arm", st, 8'h02);
    one_byte(8'h04); rdsr(st, e); chk("R2 disarm", st, 8'h00);

    wr('h010, '{8'hAA}, 0);
    rd("R7 write without enable", 'h010, 1);

    one_byte(8'h06);
    wr('h123, '{8'h11, 8'h22, 8'h33}, 0);
    rdsr(st, e); chk("R9 busy and disarmed after commit", st, 8'h01);
    chk("R9 model agrees", st, e);
    one_byte(8'h06);
    rd("R9", 'h123, 3);
    wait_idle();
    rdsr(st, e); chk("R9 arm ignored while busy", st, 8'h00);
    rd("R5 R6 read with high bit", 'h123, 3);

    one_byte(8'h06);
    wr('h0EE, '{8'hC0, 8'hC1, 8'hC2, 8'hC3}, 0);
    wait_idle();
    rd("R6 page wrap", 'h0E0, 16);

    one_byte(8'h06); wr('h1FF, '{8'h5A}, 0); wait_idle();
    one_byte(8'h06); wr('h000, '{8'hA5}, 0); wait_idle();
    rd("R5 address wrap", 'h1FE, 3);

    one_byte(8'h06);
    wr('h050, '{8'h77}, 3);
    rdsr(st, e); chk("R8 abort keeps enable, no busy", st, 8'h02);
    rd("R8 aborted byte not stored", 'h050, 1);
    one_byte(8'h04);

    wrsr(8'h3C); rdsr(st, e); chk("R4 status write without enable", st, 8'h00);
    one_byte(8'h06); wrsr(8'hFC); wait_idle();
    open_cmd(); xfer(8'h05, q); xfer(8'h00, st); xfer(8'h00, s2); close_cmd();
    chk("R3 R4 status fields", st, 8'h3C);
    chk("R3 status repeats", s2, 8'h3C);

    one_byte(8'h06); wrsr(8'h04); wait_idle();
    rdsr(st, e); chk("R4 protect field", st, 8'h04);
    one_byte(8'h06); wr('h17E, '{8'hE1}, 0); wait_idle();
    one_byte(8'h06); wr('h180, '{8'hE2}, 0); wait_idle();
    rd("R10 upper quarter", 'h17E, 3);
    one_byte(8'h06); wrsr(8'h08); wait_idle();
    one_byte(8'h06); wr('h100, '{8'hE3}, 0); wait_idle();
    one_byte(8'h06); wr('h0F0, '{8'hE4}, 0); wait_idle();
    rd("R10 upper half", 'h100, 1);
    rd("R10 lower half open", 'h0F0, 1);
    one_byte(8'h06); wrsr(8'h0C); wait_idle();
    one_byte(8'h06); wr('h020, '{8'hE5}, 0); wait_idle();
    rd("R10 all blocked", 'h020, 1);

    chk("R11 output enable while deselected", idle_viol, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule